// File: doc/BRIEF.md
# Blinking Sign Lamp Sequencer

This block drives the five lamps of a blinking roadside sign. While the run switch is on, the sign builds up in four steps: all lamps dark, then the first two lamps, then the first four, then all five. After the full step it returns to dark and starts again. The sequence moves forward one step on each clock edge where the tick strobe is high. Tying the strobe high gives one step per clock. Driving it from a slow divider elsewhere in the chip slows the sequence down.

Turning the switch off blanks the lamps at once. At the next clock edge the sequence goes back to its dark step, so every new run starts from the beginning. The step is held in a two-bit register. The lamp pattern is decoded from that register by combinational logic.

Top module: `blink_sign_seq`

## Requirements
- R1: While rst_n is sampled low at a rising clock edge, the sequence is set to its dark step. Once the switch is on, the first pattern seen is 5'b00000.
- R2: Whenever run_sw is low, lamp is 5'b00000 in the same cycle. It does not wait for a clock edge.
- R3: A clock edge with run_sw low returns the sequence to the dark step, whatever the value of tick_en. The next pattern shown after the switch comes back on is 5'b00000.
- R4: When run_sw is high and tick_en is low at a clock edge, the step does not change.
- R5: When run_sw and tick_en are both high at a clock edge, the step moves forward one place in the order dark, two lamps, four lamps, all lamps. The all-lamps step goes back to dark.
- R6: lamp[0] drives lamp 1 and lamp[4] drives lamp 5. The four steps show 5'b00000, 5'b00011, 5'b01111 and 5'b11111, in that order.
- R7: The lit lamps always form an unbroken run that starts at lamp 1. No lamp is on while a lamp below it is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run_sw | input | 1 | Run switch; high lets the sequence run, low blanks the lamps |
| tick_en | input | 1 | Advance strobe; the step moves forward only on edges where this is high |
| lamp | output | 5 | Lamp drive vector; bit 0 is lamp 1 |

## Verification
All state lives in a two-bit step register, so a wrong step appears at the lamps straight away. With the switch on, it shows in the same cycle as the wrong pattern, or as an off-by-one position in the cumulative order. A step that fails to clear when the switch goes off stays hidden while the lamps are blanked. It only shows in the first cycle after the switch comes back on, as a non-dark pattern. The stimulus therefore checks that first pattern after every off-to-on transition. It also checks that the step holds through idle ticks and wraps cleanly from the full step back to dark.

// File: rtl/lamp_seq_pkg.sv
// Shared helpers for the lamp sequencer.
// Assumes step 0 is the dark step and that each later step lights two more
// lamps than the one before it, capped at the number of lamps.
package lamp_seq_pkg;

    // Number of lamps lit at a given step of the cumulative pattern.
    function automatic int lit_count(input int step, input int lamps);
        int two_per_step;
        two_per_step = 2 * step;
        return (two_per_step > lamps) ? lamps : two_per_step;
    endfunction

endpackage

// File: rtl/seq_step_ctr.sv
// Step register for the lamp sequencer.
// It moves forward one step on each edge where run_sw and tick_en are both
// high, and wraps after the last step. An edge with run_sw low clears it.
// The reset is synchronous and active low.
module seq_step_ctr #(
    parameter int STEPS = 4,
    parameter int SW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_sw,
    input  logic          tick_en,
    output logic [SW-1:0] step_q
);
    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
    localparam logic [SW-1:0] DARK_STEP = '0;

    logic [SW-1:0] step_d;

    // Work out the next step from the switch, the strobe and the current step.
    always_comb begin
        step_d = step_q;
        if (!run_sw)
            step_d = DARK_STEP;
        else if (tick_en)
            step_d = (step_q == LAST_STEP) ? DARK_STEP : step_q + SW'(1);
    end

    // Hold the step; a low reset forces the dark step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= DARK_STEP;
        else
            step_q <= step_d;
    end

    // R1
    reset_dark_chk: assert property (@(posedge clk)
        !rst_n |=> step_q == DARK_STEP);

    // R3
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_sw |=> step_q == DARK_STEP);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sw && !tick_en) |=> $stable(step_q));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sw && tick_en && step_q == LAST_STEP) |=> step_q == DARK_STEP);

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_sw && tick_en && step_q != LAST_STEP) |=> step_q == $past(step_q) + SW'(1));

endmodule

// File: rtl/seq_lamp_decode.sv
// Turns the step number into the cumulative lamp pattern.
// Lamp i is lit when its index is below the lit count for the current step
// and the run switch is on. This block is purely combinational.
module seq_lamp_decode #(
    parameter int LAMPS = 5,
    parameter int SW    = 2
) (
    input  logic [SW-1:0]    step_q,
    input  logic             run_sw,
    output logic [LAMPS-1:0] lamp
);
    import lamp_seq_pkg::*;

    int lit_now;

    // Find how many lamps the current step lights.
    always_comb lit_now = lit_count(int'(step_q), LAMPS);

    // One comparator per lamp, all gated by the switch.
    for (genvar i = 0; i < LAMPS; i++) begin : g_lamp
        assign lamp[i] = run_sw && (i < lit_now);
    end

endmodule

// File: rtl/blink_sign_seq.sv
// Top level of the blinking sign sequencer.
// The step register and the lamp decoder are wired together here.
// It assumes tick_en is a single-cycle strobe in the clk domain, or is tied
// high for full-rate stepping.
module blink_sign_seq #(
    parameter int LAMPS = 5,
    parameter int STEPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_sw,
    input  logic             tick_en,
    output logic [LAMPS-1:0] lamp
);
    localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [SW-1:0] step_q;

    seq_step_ctr #(.STEPS(STEPS), .SW(SW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_sw  (run_sw),
        .tick_en (tick_en),
        .step_q  (step_q)
    );

    seq_lamp_decode #(.LAMPS(LAMPS), .SW(SW)) u_dec (
        .step_q (step_q),
        .run_sw (run_sw),
        .lamp   (lamp)
    );

    // R7
    contiguous_lamps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lamp + LAMPS'(1)) & lamp) == '0);

    // R2
    blank_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_sw |-> lamp == '0);

endmodule

// File: tb/blink_sign_seq_bench.sv
module blink_sign_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_sw = 1'b0;
    logic       tick_en = 1'b0;
    logic [4:0] lamp;
    int checks = 0;
    int fails  = 0;

    blink_sign_seq u_blink_sign_seq (
        .clk(clk), .rst_n(rst_n), .run_sw(run_sw), .tick_en(tick_en), .lamp(lamp)
    );

    always #4 clk = ~clk;

    // Each row holds {run_sw, tick_en, expected lamps after the edge, tag number}.
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {1'b1, 1'b1, 5'b00011, 4'd5},
        {1'b1, 1'b1, 5'b01111, 4'd6},
        {1'b1, 1'b0, 5'b01111, 4'd4},
        {1'b1, 1'b1, 5'b11111, 4'd6},
        {1'b1, 1'b1, 5'b00000, 4'd5},
        {1'b1, 1'b1, 5'b00011, 4'd5},
        {1'b0, 1'b1, 5'b00000, 4'd2},
        {1'b1, 1'b0, 5'b00000, 4'd3},
        {1'b1, 1'b1, 5'b00011, 4'd5},
        {1'b1, 1'b1, 5'b01111, 4'd6},
        {1'b0, 1'b0, 5'b00000, 4'd3},
        {1'b1, 1'b1, 5'b00011, 4'd3}
    };

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s lamp=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog lamp=%b expected=end of run", lamp);
        finish_run();
    end

    initial begin
        // R1: a held reset leaves the dark step, even with the strobe active
        run_sw = 1'b1;
        tick_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", lamp, 5'b00000);
        rst_n = 1'b1;

        // Walk the vector table. Rows with tag 2 are R2, 3 are R3, 4 are R4,
        // 5 are R5, and 6 are R6 or R7.
        for (int i = 0; i < NV; i++) begin
            run_sw = VEC[i][10];
            tick_en = VEC[i][9];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d row%0d", VEC[i][3:0], i), lamp, VEC[i][8:4]);
        end

        // R2: dropping the switch blanks the lamps before any edge
        run_sw = 1'b1;
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R6 four lamps", lamp, 5'b01111);
        run_sw = 1'b0;
        #1;
        check("R2 immediate blank", lamp, 5'b00000);

        // R3: after the off edge, the run restarts dark when tick_en is low
        @(posedge clk);
        @(negedge clk);
        run_sw = 1'b1;
        tick_en = 1'b0;
        #1;
        check("R3 restart dark", lamp, 5'b00000);

        // R4: several idle edges hold the two-lamp step
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 long hold", lamp, 5'b00011);

        // R1: a mid-run reset returns the sequence to dark
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 contiguous four", lamp, 5'b01111);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", lamp, 5'b00000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R5 after reset", lamp, 5'b00011);

        finish_run();
    end
endmodule